// File: doc/BRIEF.md
# 40-Cell Horizontal Line Timer

This block produces the horizontal timing of one raster line in the 40-cell display mode. It is advanced by a one-cycle pixel enable and keeps an 8-bit horizontal count. The count moves on once per two pixels and skips from 0xB6 straight to 0xE4. The two values at the skip each last a single pixel, so a line is 420 pixels long. A phase bit beside the count records which pixel of a pair is current, so edges that fall in the middle of a count value are placed on the correct pixel.

The position on the line is decoded into level outputs: horizontal blank, left and right border, active display, an active-low horizontal sync, and a flag that marks the stretched pixels between the two sync edges. Single-clock strobes mark three events. The first tells the vertical counter to advance and the second marks the horizontal-interrupt point; both fire as the count reaches 0xA5. The third marks the vertical-interrupt point when the count wraps to 0x00, if an external input reports that the line just finished was the last active line. All trip points are fixed counter values and do not depend on the video standard.

Top module: `h40_line_timer`

## Requirements
- R1: While reset is asserted, and until a pixel enable is accepted after release, hcount_o is 0x00 on the first pixel of that value, hblank_o is 1, hsync_n_o is 1, and border_o, active_o, stretch_o, vinc_o, hint_o and vint_o are 0.
- R2: The count changes only on a clock with pix_en_i high. Apart from 0xB6 and 0xE4, each count value lasts exactly two enabled pixels and is then followed by the value plus one. 0xFF is followed by 0x00.
- R3: 0xB6 and 0xE4 each last exactly one enabled pixel, and the value after 0xB6 is 0xE4, so a line spans 420 enabled pixels.
- R4: hblank_o is 0 from the first pixel of count 0x05 up to the last pixel before count 0xB3, and 1 elsewhere on the line.
- R5: active_o is 1 from the first pixel of 0x0D up to the last pixel before 0xAD. border_o is 1 from the second pixel of 0x06 up to the pixel before 0x0D, and again from the first pixel of 0xAD up to the pixel before 0xB4. Both are 0 elsewhere.
- R6: hsync_n_o is 0 from the second pixel of 0xE6 up to and including the first pixel of 0xF6, and 1 elsewhere. stretch_o is 1 over exactly the same pixels.
- R7: vinc_o and hint_o are high together for one clock, in the first clock in which hcount_o shows the first pixel of 0xA5, and are low at all other times.
- R8: vint_o is high for one clock, in the first clock in which hcount_o shows 0x00 after a wrap, when line_last_i was high on the clock edge that made the wrap. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en_i | input | 1 | One-clock pixel enable; each high cycle is one pixel |
| line_last_i | input | 1 | High while the line being finished is the last active line |
| hcount_o | output | 8 | Horizontal count |
| hblank_o | output | 1 | Horizontal blank flag |
| border_o | output | 1 | Left or right border region |
| active_o | output | 1 | Active display region |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| stretch_o | output | 1 | Stretched-pixel region between the sync edges |
| vinc_o | output | 1 | One-clock strobe to advance the vertical counter |
| hint_o | output | 1 | One-clock horizontal-interrupt point |
| vint_o | output | 1 | One-clock vertical-interrupt point at wrap |

## Verification
The bench builds the block with its default parameters, which are the 8-bit count and the 40-cell trip points. Every decoded edge, the skip at 0xB6 and the wrap therefore fall at the pixel indices the requirements name. Long runs with the enable held high cover several whole lines back to back. Random gaps in the enable show that the count and strobes wait for the enable. A random last-line input gates the wrap strobe, and a reset in the middle of a line returns the block to its start state.

// File: rtl/h40_line_pkg.sv
package h40_line_pkg;

  localparam int H40_CNT_W        = 8;
  localparam int H40_JUMP_FROM    = 'hB6;
  localparam int H40_JUMP_TO      = 'hE4;
  localparam int H40_HBLANK_END   = 'h05;
  localparam int H40_HBLANK_START = 'hB3;
  localparam int H40_BORDER_L     = 'h06;
  localparam int H40_ACTIVE_START = 'h0D;
  localparam int H40_ACTIVE_END   = 'hAD;
  localparam int H40_BORDER_R_END = 'hB4;
  localparam int H40_VINC_AT      = 'hA5;
  localparam int H40_SYNC_FALL    = 'hE6;
  localparam int H40_SYNC_RISE    = 'hF6;

  typedef struct packed {
    logic hblank;
    logic border;
    logic active;
    logic sync_low;
  } h40_win_t;

endpackage

// File: rtl/h40_phase_counter.sv
module h40_phase_counter #(
  parameter int CNT_W     = 8,
  parameter int JUMP_FROM = 'hB6,
  parameter int JUMP_TO   = 'hE4,
  localparam int PW       = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  output logic [PW-1:0] pos_o,
  output logic [PW-1:0] nxt_pos_o
);

  localparam logic [CNT_W-1:0] JF = CNT_W'(JUMP_FROM);
  localparam logic [CNT_W-1:0] JT = CNT_W'(JUMP_TO);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             single;

  // Next-state: second pixel of a pair, or a single-pixel value, moves on
  always_comb begin
    single = (cnt_q == JF) || (cnt_q == JT);
    if (!ph_q && !single) begin
      cnt_d = cnt_q;
      ph_d  = 1'b1;
    end else begin
      ph_d  = 1'b0;
      cnt_d = (cnt_q == JF) ? JT : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (ce) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign pos_o     = {cnt_q, ph_q};
  assign nxt_pos_o = {cnt_d, ph_d};

endmodule

// File: rtl/h40_window_decode.sv
module h40_window_decode
  import h40_line_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int HBLANK_END   = 'h05,
  parameter int HBLANK_START = 'hB3,
  parameter int BORDER_L     = 'h06,
  parameter int ACTIVE_START = 'h0D,
  parameter int ACTIVE_END   = 'hAD,
  parameter int BORDER_R_END = 'hB4,
  parameter int SYNC_FALL    = 'hE6,
  parameter int SYNC_RISE    = 'hF6,
  localparam int PW          = CNT_W + 1
) (
  input  logic [PW-1:0] pos_i,
  output h40_win_t      win_o
);

  // Positions in half-count units: {count, phase}
  localparam logic [PW-1:0] P_HB_END  = {CNT_W'(HBLANK_END),   1'b0};
  localparam logic [PW-1:0] P_HB_BEG  = {CNT_W'(HBLANK_START), 1'b0};
  localparam logic [PW-1:0] P_BL_BEG  = {CNT_W'(BORDER_L),     1'b1};
  localparam logic [PW-1:0] P_AC_BEG  = {CNT_W'(ACTIVE_START), 1'b0};
  localparam logic [PW-1:0] P_AC_END  = {CNT_W'(ACTIVE_END),   1'b0};
  localparam logic [PW-1:0] P_BR_END  = {CNT_W'(BORDER_R_END), 1'b0};
  localparam logic [PW-1:0] P_SY_BEG  = {CNT_W'(SYNC_FALL),    1'b1};
  localparam logic [PW-1:0] P_SY_END  = {CNT_W'(SYNC_RISE),    1'b1};

  function automatic logic in_win(input logic [PW-1:0] p,
                                  input logic [PW-1:0] lo,
                                  input logic [PW-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  always_comb begin
    win_o.hblank   = !in_win(pos_i, P_HB_END, P_HB_BEG);
    win_o.active   = in_win(pos_i, P_AC_BEG, P_AC_END);
    win_o.border   = in_win(pos_i, P_BL_BEG, P_AC_BEG) ||
                     in_win(pos_i, P_AC_END, P_BR_END);
    win_o.sync_low = in_win(pos_i, P_SY_BEG, P_SY_END);
  end

endmodule

// File: rtl/h40_event_pulse.sv
module h40_event_pulse #(
  parameter int CNT_W    = 8,
  parameter int TRIG_CNT = 0,
  localparam int PW      = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          gate,
  input  logic [PW-1:0] nxt_pos_i,
  output logic          pulse_o
);

  localparam logic [PW-1:0] TRIG_POS = {CNT_W'(TRIG_CNT), 1'b0};

  logic pulse_d, pulse_q;

  always_comb begin
    pulse_d = ce && gate && (nxt_pos_i == TRIG_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/h40_line_timer.sv
module h40_line_timer
  import h40_line_pkg::*;
#(
  parameter int CNT_W        = H40_CNT_W,
  parameter int JUMP_FROM    = H40_JUMP_FROM,
  parameter int JUMP_TO      = H40_JUMP_TO,
  parameter int HBLANK_END   = H40_HBLANK_END,
  parameter int HBLANK_START = H40_HBLANK_START,
  parameter int BORDER_L     = H40_BORDER_L,
  parameter int ACTIVE_START = H40_ACTIVE_START,
  parameter int ACTIVE_END   = H40_ACTIVE_END,
  parameter int BORDER_R_END = H40_BORDER_R_END,
  parameter int VINC_AT      = H40_VINC_AT,
  parameter int SYNC_FALL    = H40_SYNC_FALL,
  parameter int SYNC_RISE    = H40_SYNC_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en_i,
  input  logic             line_last_i,
  output logic [CNT_W-1:0] hcount_o,
  output logic             hblank_o,
  output logic             border_o,
  output logic             active_o,
  output logic             hsync_n_o,
  output logic             stretch_o,
  output logic             vinc_o,
  output logic             hint_o,
  output logic             vint_o
);

  localparam int PW = CNT_W + 1;

  logic          rst_s1_q, rst_s2_q;
  logic [PW-1:0] pos, nxt_pos;
  h40_win_t      win;
  logic          vinc_pulse;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  h40_phase_counter #(
    .CNT_W    (CNT_W),
    .JUMP_FROM(JUMP_FROM),
    .JUMP_TO  (JUMP_TO)
  ) i_counter (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .ce       (pix_en_i),
    .pos_o    (pos),
    .nxt_pos_o(nxt_pos)
  );

  h40_window_decode #(
    .CNT_W       (CNT_W),
    .HBLANK_END  (HBLANK_END),
    .HBLANK_START(HBLANK_START),
    .BORDER_L    (BORDER_L),
    .ACTIVE_START(ACTIVE_START),
    .ACTIVE_END  (ACTIVE_END),
    .BORDER_R_END(BORDER_R_END),
    .SYNC_FALL   (SYNC_FALL),
    .SYNC_RISE   (SYNC_RISE)
  ) i_decode (
    .pos_i(pos),
    .win_o(win)
  );

  h40_event_pulse #(
    .CNT_W   (CNT_W),
    .TRIG_CNT(VINC_AT)
  ) i_vinc_pulse (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .ce       (pix_en_i),
    .gate     (1'b1),
    .nxt_pos_i(nxt_pos),
    .pulse_o  (vinc_pulse)
  );

  h40_event_pulse #(
    .CNT_W   (CNT_W),
    .TRIG_CNT(0)
  ) i_vint_pulse (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .ce       (pix_en_i),
    .gate     (line_last_i),
    .nxt_pos_i(nxt_pos),
    .pulse_o  (vint_o)
  );

  assign hcount_o  = pos[PW-1:1];
  assign hblank_o  = win.hblank;
  assign border_o  = win.border;
  assign active_o  = win.active;
  assign hsync_n_o = !win.sync_low;
  assign stretch_o = win.sync_low;
  assign vinc_o    = vinc_pulse;
  assign hint_o    = vinc_pulse;

endmodule

// File: rtl/h40_line_timer_chk.sv
module h40_line_timer_chk #(
  parameter int CNT_W     = 8,
  parameter int JUMP_FROM = 'hB6,
  parameter int JUMP_TO   = 'hE4,
  parameter int VINC_AT   = 'hA5,
  parameter int SYNC_FALL = 'hE6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en_i,
  input logic             line_last_i,
  input logic [CNT_W-1:0] hcount_o,
  input logic             hblank_o,
  input logic             border_o,
  input logic             active_o,
  input logic             hsync_n_o,
  input logic             stretch_o,
  input logic             vinc_o,
  input logic             hint_o,
  input logic             vint_o
);

  localparam logic [CNT_W-1:0] JF = CNT_W'(JUMP_FROM);
  localparam logic [CNT_W-1:0] JT = CNT_W'(JUMP_TO);
  localparam logic [CNT_W-1:0] VA = CNT_W'(VINC_AT);
  localparam logic [CNT_W-1:0] SF = CNT_W'(SYNC_FALL);

  logic [CNT_W-1:0] cnt_plus;
  assign cnt_plus = hcount_o + CNT_W'(1);

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en_i |=> $stable(hcount_o)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en_i |=> (hcount_o == $past(hcount_o)) || (hcount_o == $past(cnt_plus)) ||
                 (($past(hcount_o) == JF) && (hcount_o == JT))); // R2

  AST_JUMP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en_i && hcount_o == JF) |=> (hcount_o == JT)); // R3

  AST_ACTIVE_NOT_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_o && border_o)); // R5

  AST_ACTIVE_NOT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !hblank_o); // R4

  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n_o |-> hblank_o); // R6

  AST_STRETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_o) |-> (hcount_o == SF)); // R6

  AST_VINC_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    vinc_o |-> (hcount_o == VA)); // R7

  AST_HINT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    hint_o |-> (hcount_o == VA)); // R7

  AST_VINT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    vint_o |-> (hcount_o == '0) && $past(line_last_i) && $past(pix_en_i)); // R8

endmodule

bind h40_line_timer h40_line_timer_chk #(
  .CNT_W    (CNT_W),
  .JUMP_FROM(JUMP_FROM),
  .JUMP_TO  (JUMP_TO),
  .VINC_AT  (VINC_AT),
  .SYNC_FALL(SYNC_FALL)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_en_i   (pix_en_i),
  .line_last_i(line_last_i),
  .hcount_o   (hcount_o),
  .hblank_o   (hblank_o),
  .border_o   (border_o),
  .active_o   (active_o),
  .hsync_n_o  (hsync_n_o),
  .stretch_o  (stretch_o),
  .vinc_o     (vinc_o),
  .hint_o     (hint_o),
  .vint_o     (vint_o)
);

// File: tb/test_h40_line_timer.sv
`timescale 1ns/1ps
module test_h40_line_timer;

  localparam int LINE_PIX = 420;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en;
  logic       line_last;
  logic [7:0] hcount;
  logic       hblank, border, active, hsync_n, stretch, vinc, hint, vint;

  int n_tests = 0;
  int n_fail  = 0;
  int p       = 0;
  logic e_vinc = 1'b0;
  logic e_vint = 1'b0;

  always #2 clk = ~clk;

  h40_line_timer i_h40_line_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en_i   (pix_en),
    .line_last_i(line_last),
    .hcount_o   (hcount),
    .hblank_o   (hblank),
    .border_o   (border),
    .active_o   (active),
    .hsync_n_o  (hsync_n),
    .stretch_o  (stretch),
    .vinc_o     (vinc),
    .hint_o     (hint),
    .vint_o     (vint)
  );

  // Pixel index on the line -> expected count
  function automatic int exp_cnt(int pix);
    if (pix <= 363)      return pix / 2;
    else if (pix == 364) return 'hB6;
    else if (pix == 365) return 'hE4;
    else                 return 'hE5 + (pix - 366) / 2;
  endfunction

  function automatic bit exp_hblank(int pix);
    return (pix < 10) || (pix >= 358);
  endfunction

  function automatic bit exp_active(int pix);
    return (pix >= 26) && (pix < 346);
  endfunction

  function automatic bit exp_border(int pix);
    return ((pix >= 13) && (pix < 26)) || ((pix >= 346) && (pix < 360));
  endfunction

  function automatic bit exp_sync_low(int pix);
    return (pix >= 369) && (pix < 401);
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h (pixel %0d)", req, what, got, exp, p);
    end
  endtask

  task automatic check_all();
    chk((p >= 364 && p <= 366) ? "R3" : "R2", "hcount", int'(hcount), exp_cnt(p));
    chk("R4", "hblank", int'(hblank), int'(exp_hblank(p)));
    chk("R5", "active", int'(active), int'(exp_active(p)));
    chk("R5", "border", int'(border), int'(exp_border(p)));
    chk("R6", "hsync_n", int'(hsync_n), int'(!exp_sync_low(p)));
    chk("R6", "stretch", int'(stretch), int'(exp_sync_low(p)));
    chk("R7", "vinc", int'(vinc), int'(e_vinc));
    chk("R7", "hint", int'(hint), int'(e_vinc));
    chk("R8", "vint", int'(vint), int'(e_vint));
  endtask

  task automatic check_reset_state();
    chk("R1", "hcount", int'(hcount), 0);
    chk("R1", "hblank", int'(hblank), 1);
    chk("R1", "hsync_n", int'(hsync_n), 1);
    chk("R1", "border", int'(border), 0);
    chk("R1", "active", int'(active), 0);
    chk("R1", "stretch", int'(stretch), 0);
    chk("R1", "vinc", int'(vinc), 0);
    chk("R1", "hint", int'(hint), 0);
    chk("R1", "vint", int'(vint), 0);
  endtask

  // Drive at the falling edge, model at the rising edge, check at the next fall
  task automatic run_cycle(bit en, bit last);
    pix_en    = en;
    line_last = last;
    @(posedge clk);
    if (en) begin
      p      = (p + 1) % LINE_PIX;
      e_vinc = (p == 330);
      e_vint = (p == 0) && last;
    end else begin
      e_vinc = 1'b0;
      e_vint = 1'b0;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    pix_en = 1'b0;
    p      = 0;
    e_vinc = 1'b0;
    e_vint = 1'b0;
    #1;
    check_reset_state();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) run_cycle(1'b0, 1'b0);
    check_reset_state();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit last;
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    pix_en    = 1'b0;
    line_last = 1'b0;
    do_reset();

    // Whole lines with the enable held high; last-line input toggles per line
    last = 1'b1;
    for (int i = 0; i < 3 * LINE_PIX + 17; i++) begin
      if (p == LINE_PIX - 1) last = ~last;
      run_cycle(1'b1, last);
    end

    // Random enable gaps and random last-line input
    for (int i = 0; i < 4000; i++) begin
      run_cycle(($urandom % 4) != 0, ($urandom % 2) == 1);
    end

    // Directed: a stall right on the skip value and on the strobe point
    while (p != 364) run_cycle(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) run_cycle(1'b0, 1'b0);
    for (int i = 0; i < 2; i++) run_cycle(1'b1, 1'b0);
    while (p != 329) run_cycle(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) run_cycle(1'b0, 1'b1);
    run_cycle(1'b1, 1'b1);
    while (p != LINE_PIX - 1) run_cycle(1'b1, 1'b0);
    run_cycle(1'b1, 1'b1);

    // Reset in the middle of a line
    for (int i = 0; i < 200; i++) run_cycle(1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < LINE_PIX + 50; i++) run_cycle(1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule